// File: doc/BRIEF.md
# Cursor Overlay Blender

This block lays a square cursor bitmap over a raster stream of active-video pixels. Incoming pixels carry a start-of-frame flag on the first pixel of a frame and an end-of-line flag on the last pixel of each line. From these flags the block tracks the column and row of every pixel. A pair of shadow position inputs gives the top-left corner of the cursor in pixels, counted from the first active pixel. The block copies that pair into its working position only on the start-of-frame pixel, so the cursor moves at most once per frame.

The cursor bitmap sits in an internal RAM with one write port. Each word holds one cursor pixel with 4-bit red, green, blue and alpha fields. Pixels that the cursor covers are alpha-blended with the matching bitmap word. All other pixels pass through untouched. Parts of the cursor that lie beyond the right or bottom edge of the image never meet a pixel, so they are cropped without extra logic. A cursor that looks smaller than the bitmap is made by writing alpha 0 into its border words.

The bitmap is CUR_LOG2 bits on a side. The deployed configuration sets CUR_LOG2 to 7, which gives a 128 by 128 cursor held in 32 KB. The default of 5 keeps elaboration small. Pixels move through two register stages. Output follows input by exactly two clocks, and the block accepts one pixel every clock.

Top module: `cursor_overlay`

## Requirements
- R1: A pixel outside the cursor window leaves the block bit-identical, two clocks after it entered.
- R2: A covered pixel is blended per channel. The 4-bit cursor color c becomes 12 bits as c*0x111, and alpha a becomes 8 bits as A=a*0x11. If a is 15 the output channel equals the expanded color. Otherwise it equals (C*A + P*(256-A)) >> 8, where C is the expanded color and P is the input channel.
- R3: A covered pixel whose cursor word has alpha 0 leaves the block unchanged.
- R4: The RAM word at address row*2^CUR_LOG2+col belongs to image pixel (cur_x+col, cur_y+row). Within a word, bits 15:12 are red, 11:8 green, 7:4 blue and 3:0 alpha. Within a pixel, the top PIX_W bits are red, then green, and the low bits are blue.
- R5: Shadow position changes made during a frame have no effect until the next start-of-frame pixel. On that pixel the new position already applies.
- R6: Cursor columns or rows that fall beyond the image are cropped. Pixels at the start of the next line or frame are not affected by them.
- R7: out_valid, out_sof and out_eol repeat in_valid, in_sof and in_eol with a two-clock delay, aligned with out_pix.
- R8: During and right after reset, out_valid is low.
- R9: Back-to-back input pixels produce back-to-back outputs, with no stall and no dropped pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bmp_we | input | 1 | Cursor RAM write enable |
| bmp_waddr | input | 2*CUR_LOG2 | Cursor RAM write address (row*2^CUR_LOG2+col) |
| bmp_wdata | input | 16 | Cursor word {R,G,B,A}, 4 bits each |
| cur_x | input | POS_W | Shadow cursor column |
| cur_y | input | POS_W | Shadow cursor row |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of frame |
| in_eol | input | 1 | Last pixel of line |
| in_pix | input | 3*PIX_W | Input pixel {R,G,B} |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed start-of-frame flag |
| out_eol | output | 1 | Delayed end-of-line flag |
| out_pix | output | 3*PIX_W | Output pixel {R,G,B} |

## Verification
The bench loads random cursor words into the bitmap, along with fully opaque and fully transparent words. It then runs frames with random idle gaps, with the cursor placed inside the image, hanging off the bottom-right corner, and parked on the very last pixel.

A design that wraps the window horizontally would blend the first pixels of the following line. One that misses the alpha-15 case would darken the opaque words by one step. One that latches the position on a write rather than on the start-of-frame pixel would move the cursor in the middle of a frame. Alpha-0 words catch an off-by-one in the blend weight, and a skew between the flags and the pixel shows up as misaligned frame or line markers.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;

   localparam int BMP_W = 16;

   typedef struct packed {
      logic [3:0] red;
      logic [3:0] grn;
      logic [3:0] blu;
      logic [3:0] alp;
   } bmp_word_t;

   function automatic logic [7:0] widen_alpha(input logic [3:0] a4);
      return {a4, a4};
   endfunction

endpackage

// File: rtl/cursor_raster_tracker.sv
module cursor_raster_tracker #(
   parameter int POS_W    = 12,
   parameter int CUR_LOG2 = 5,
   localparam int AW      = 2 * CUR_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eol,
   input  logic [POS_W-1:0] shadow_x,
   input  logic [POS_W-1:0] shadow_y,
   output logic             win_hit,
   output logic [AW-1:0]    win_addr,
   output logic [POS_W-1:0] live_x,
   output logic [POS_W-1:0] live_y
);

   localparam logic [POS_W-1:0] SPAN = POS_W'(1 << CUR_LOG2);

   logic [POS_W-1:0] col_q, row_q, col_now, row_now, org_x, org_y;
   logic [POS_W:0]   dx, dy;
   logic             in_x, in_y;

   always_comb begin
      col_now  = in_sof ? '0 : col_q;
      row_now  = in_sof ? '0 : row_q;
      org_x    = in_sof ? shadow_x : live_x;
      org_y    = in_sof ? shadow_y : live_y;
      dx       = {1'b0, col_now} - {1'b0, org_x};
      dy       = {1'b0, row_now} - {1'b0, org_y};
      in_x     = !dx[POS_W] && (dx[POS_W-1:0] < SPAN);
      in_y     = !dy[POS_W] && (dy[POS_W-1:0] < SPAN);
      win_hit  = in_x && in_y;
      win_addr = {dy[CUR_LOG2-1:0], dx[CUR_LOG2-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         live_x <= '0;
         live_y <= '0;
      end else if (in_valid) begin
         if (in_sof) begin
            live_x <= shadow_x;
            live_y <= shadow_y;
         end
         if (in_eol) begin
            col_q <= '0;
            row_q <= row_now + 1'b1;
         end else begin
            col_q <= col_now + 1'b1;
            row_q <= row_now;
         end
      end
   end

endmodule

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram #(
   parameter int AW = 10,
   parameter int DW = 16,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/cursor_alpha_mix.sv
module cursor_alpha_mix #(
   parameter int PIX_W = 12,
   localparam int MW   = PIX_W + 9
) (
   input  logic [PIX_W-1:0] bg,
   input  logic [3:0]       fg4,
   input  logic [3:0]       a4,
   output logic [PIX_W-1:0] mixed
);
   import cursor_overlay_pkg::*;

   logic [PIX_W-1:0] fg;
   logic [7:0]       a8;
   logic [MW-1:0]    acc;

   for (genvar k = 0; k < PIX_W; k++) begin : g_rep
      assign fg[PIX_W-1-k] = fg4[3 - (k % 4)];
   end

   always_comb begin
      a8  = widen_alpha(a4);
      acc = MW'(fg) * MW'(a8) + MW'(bg) * (MW'(256) - MW'(a8));
      if (a8 == 8'hFF) mixed = fg;
      else             mixed = acc[PIX_W+7:8];
   end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
   parameter int PIX_W    = 12,
   parameter int POS_W    = 12,
   parameter int CUR_LOG2 = 5,
   localparam int AW      = 2 * CUR_LOG2,
   localparam int PW      = 3 * PIX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bmp_we,
   input  logic [AW-1:0]    bmp_waddr,
   input  logic [15:0]      bmp_wdata,
   input  logic [POS_W-1:0] cur_x,
   input  logic [POS_W-1:0] cur_y,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eol,
   input  logic [PW-1:0]    in_pix,
   output logic             out_valid,
   output logic             out_sof,
   output logic             out_eol,
   output logic [PW-1:0]    out_pix
);
   import cursor_overlay_pkg::*;

   if (PIX_W < 4 || PIX_W > 16) begin : g_bad_pix
      $error("PIX_W must lie in 4..16");
   end
   if (POS_W <= CUR_LOG2) begin : g_bad_pos
      $error("POS_W must exceed CUR_LOG2");
   end
   if (CUR_LOG2 < 1 || CUR_LOG2 > 7) begin : g_bad_cur
      $error("CUR_LOG2 must lie in 1..7");
   end

   logic             hit0;
   logic [AW-1:0]    addr0;
   logic [POS_W-1:0] live_x, live_y;
   logic             s1_valid, s1_sof, s1_eol, s1_hit;
   logic [PW-1:0]    s1_pix, mix_pix;
   logic [BMP_W-1:0] ram_q;
   bmp_word_t        cw;

   cursor_raster_tracker #(.POS_W(POS_W), .CUR_LOG2(CUR_LOG2)) u_track (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eol(in_eol), .shadow_x(cur_x), .shadow_y(cur_y),
      .win_hit(hit0), .win_addr(addr0), .live_x(live_x), .live_y(live_y)
   );

   cursor_bitmap_ram #(.AW(AW), .DW(BMP_W)) u_ram (
      .clk(clk), .we(bmp_we), .waddr(bmp_waddr), .wdata(bmp_wdata),
      .re(in_valid && hit0), .raddr(addr0), .rdata(ram_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
         s1_eol   <= 1'b0;
         s1_hit   <= 1'b0;
         s1_pix   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_sof   <= in_valid && in_sof;
         s1_eol   <= in_valid && in_eol;
         s1_hit   <= in_valid && hit0;
         s1_pix   <= in_pix;
      end
   end

   assign cw = bmp_word_t'(ram_q);

   for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      logic [3:0] nib;
      assign nib = (ch == 0) ? cw.red : (ch == 1) ? cw.grn : cw.blu;
      cursor_alpha_mix #(.PIX_W(PIX_W)) u_mix (
         .bg(s1_pix[(3-ch)*PIX_W-1 -: PIX_W]), .fg4(nib), .a4(cw.alp),
         .mixed(mix_pix[(3-ch)*PIX_W-1 -: PIX_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= s1_valid;
         out_sof   <= s1_sof;
         out_eol   <= s1_eol;
         out_pix   <= s1_hit ? mix_pix : s1_pix;
      end
   end

endmodule

// File: rtl/cursor_overlay_checker.sv
module cursor_overlay_checker #(
   parameter int PIX_W = 12,
   parameter int POS_W = 12,
   localparam int PW   = 3 * PIX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sof,
   input logic             out_valid,
   input logic             out_sof,
   input logic             out_eol,
   input logic [PW-1:0]    out_pix,
   input logic             s1_valid,
   input logic             s1_hit,
   input logic [PW-1:0]    s1_pix,
   input logic [15:0]      ram_q,
   input logic [POS_W-1:0] live_x,
   input logic [POS_W-1:0] live_y
);

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       age <= '0;
      else if (age < 2) age <= age + 1'b1;
   end

   function automatic logic [PW-1:0] opaque_of(input logic [15:0] w);
      logic [PW-1:0] r;
      for (int ch = 0; ch < 3; ch++)
         for (int k = 0; k < PIX_W; k++)
            r[(3-ch)*PIX_W-1-k] = w[15-4*ch-(k%4)];
      return r;
   endfunction

   assert_reset_quiet_R8: assert property (@(posedge clk) !rst_n |=> !out_valid);

   assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2) |-> (out_valid == $past(in_valid, 2)));

   assert_sof_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2) |-> (out_sof == $past(in_valid && in_sof, 2)));

   assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eol) |-> out_valid);

   assert_pass_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_hit) |=> (out_pix == $past(s1_pix)));

   assert_opaque_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_hit && ram_q[3:0] == 4'hF) |=> (out_pix == opaque_of($past(ram_q))));

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_hit && ram_q[3:0] == 4'h0) |=> (out_pix == $past(s1_pix)));

   assert_pos_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_sof) |=> ($stable(live_x) && $stable(live_y)));

endmodule

bind cursor_overlay cursor_overlay_checker #(.PIX_W(PIX_W), .POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
   .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix),
   .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_pix(s1_pix), .ram_q(ram_q),
   .live_x(live_x), .live_y(live_y)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

   localparam int PIX_W = 12;
   localparam int POS_W = 12;
   localparam int CUR_LOG2 = 5;
   localparam int DIM = 1 << CUR_LOG2;
   localparam int AW = 2 * CUR_LOG2;
   localparam int PW = 3 * PIX_W;
   localparam int IMG_W = 48;
   localparam int IMG_H = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bmp_we = 1'b0;
   logic [AW-1:0] bmp_waddr = '0;
   logic [15:0] bmp_wdata = '0;
   logic [POS_W-1:0] cur_x = '0, cur_y = '0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [PW-1:0] in_pix = '0;
   logic out_valid, out_sof, out_eol;
   logic [PW-1:0] out_pix;

   always #4 clk = ~clk;

   cursor_overlay #(.PIX_W(PIX_W), .POS_W(POS_W), .CUR_LOG2(CUR_LOG2)) u_cursor_overlay (
      .clk(clk), .rst_n(rst_n), .bmp_we(bmp_we), .bmp_waddr(bmp_waddr),
      .bmp_wdata(bmp_wdata), .cur_x(cur_x), .cur_y(cur_y), .in_valid(in_valid),
      .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix), .out_valid(out_valid),
      .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
   );

   logic [15:0] model [DIM*DIM];
   logic [PW-1:0] q_pix[$];
   bit q_sof[$];
   bit q_eol[$];
   string q_tag[$];
   bit prev_v = 1'b0;
   bit monitor_on = 1'b0;
   int checks = 0, errors = 0;

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int mix_chan(int p, int c, int a);
      int cc = c * 273;
      int aa = a * 17;
      if (a == 15) return cc;
      return (cc * aa + p * (256 - aa)) >> 8;
   endfunction

   function automatic logic [PW-1:0] blend_pix(logic [PW-1:0] p, logic [15:0] w);
      logic [PW-1:0] r;
      for (int ch = 0; ch < 3; ch++) begin
         int pv = int'(p[(2-ch)*PIX_W +: PIX_W]);
         int cv = int'(w[15-4*ch -: 4]);
         r[(2-ch)*PIX_W +: PIX_W] = PIX_W'(mix_chan(pv, cv, int'(w[3:0])));
      end
      return r;
   endfunction

   task automatic monitor();
      if (!monitor_on) return;
      check(out_valid == prev_v, "R9", "out_valid cadence", 64'(out_valid), 64'(prev_v));
      if (out_valid) begin
         if (q_pix.size() == 0) begin
            check(1'b0, "R9", "unexpected output", 64'(1), 64'(0));
         end else begin
            logic [PW-1:0] ep = q_pix.pop_front();
            bit es = q_sof.pop_front();
            bit ee = q_eol.pop_front();
            string et = q_tag.pop_front();
            check(out_pix == ep, et, "pixel", 64'(out_pix), 64'(ep));
            check(out_sof == es && out_eol == ee, "R7", "markers",
                  64'({out_sof, out_eol}), 64'({es, ee}));
         end
      end
      prev_v = in_valid;
   endtask

   task automatic step(bit v, bit s, bit e, logic [PW-1:0] p);
      @(negedge clk);
      monitor();
      in_valid = v;
      in_sof = s;
      in_eol = e;
      in_pix = p;
      bmp_we = 1'b0;
   endtask

   task automatic run_frame(int px, int py, string out_tag, int move_row, int nx, int ny);
      cur_x = POS_W'(px);
      cur_y = POS_W'(py);
      for (int y = 0; y < IMG_H; y++) begin
         for (int x = 0; x < IMG_W; x++) begin
            logic [PW-1:0] p = PW'({$urandom, $urandom});
            int dx = x - px;
            int dy = y - py;
            if ($urandom % 5 == 0) step(1'b0, 1'b0, 1'b0, '0);
            if (move_row >= 0 && y == move_row && x == 0) begin
               cur_x = POS_W'(nx);
               cur_y = POS_W'(ny);
            end
            step(1'b1, (x == 0 && y == 0), (x == IMG_W - 1), p);
            if (dx >= 0 && dx < DIM && dy >= 0 && dy < DIM) begin
               logic [15:0] w = model[dy*DIM+dx];
               q_pix.push_back(blend_pix(p, w));
               q_tag.push_back(w[3:0] == 4'h0 ? "R3" : "R2 R4");
            end else begin
               q_pix.push_back(p);
               q_tag.push_back(out_tag);
            end
            q_sof.push_back(x == 0 && y == 0);
            q_eol.push_back(x == IMG_W - 1);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8", "out_valid in reset", 64'(out_valid), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_sof == 1'b0, "R8", "after reset",
            64'({out_valid, out_sof}), 64'(0));
      for (int i = 0; i < DIM * DIM; i++) begin
         logic [15:0] w = 16'($urandom);
         if (i % 7 == 0) w[3:0] = 4'hF;
         if (i % 11 == 0 || (i % DIM) == DIM - 1) w[3:0] = 4'h0;
         model[i] = w;
         @(negedge clk);
         bmp_we = 1'b1;
         bmp_waddr = AW'(i);
         bmp_wdata = w;
      end
      @(negedge clk);
      bmp_we = 1'b0;
      monitor_on = 1'b1;
      run_frame(5, 3, "R1", -1, 0, 0);
      run_frame(30, 20, "R6", -1, 0, 0);
      run_frame(12, 8, "R5", 10, 0, 0);
      run_frame(0, 0, "R5", -1, 0, 0);
      run_frame(IMG_W - 1, IMG_H - 1, "R6", -1, 0, 0);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0);
      check(q_pix.size() == 0, "R9", "all pixels emitted", 64'(q_pix.size()), 64'(0));
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule